// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block sits on the controller side of a mobile SDRAM and takes the device into and out of its two low-power states. The first is ordinary power-down, where the clock enable is dropped and the array keeps its contents. The second is deep power-down, where the array is switched off and its contents are lost. The block drives the clock-enable pin and the four active-low command strobes. It takes single-cycle request pulses for the four moves: enter power-down, leave power-down, enter deep power-down and leave deep power-down. It refuses to enter either state unless every bank is reported idle.

Leaving deep power-down is a long affair. The block raises CKE and holds NOP on the bus for a stabilisation window, which is a cycle count computed from the clock frequency and the required time in microseconds. It then sends a one-cycle start pulse to an external initialisation engine and stays busy until that engine reports done. Only after that does it report the device ready for normal traffic.

All ports are plain control and status pins. Requests are not back-pressured. A request that cannot be honoured in the current cycle is dropped, and the drop is reported by an error pulse in the next cycle.

Top module: `sdram_lp_seq`

## Requirements
- R1: After reset the block is ready (ready=1, busy=0), CKE is high, the command is NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), and req_err and init_start are low.
- R2: A lone enter-power-down request while ready and with banks idle gives, in the next cycle, CKE low with NOP and busy=1 for one cycle. After that the block stays in power-down with CKE low, busy=0 and ready=0 until an exit request.
- R3: An enter request (either kind) made while banks_idle=0 is rejected. The block stays ready with CKE high.
- R4: A leave-power-down request while in power-down raises CKE with NOP and holds busy=1 for exactly CKS_CYCLES cycles, which is the CKE setup time. The block is then ready.
- R5: A lone enter-deep-power-down request while ready and with banks idle drives, for one cycle, CKE low with cs_n=0, ras_n=1, cas_n=1, we_n=0. From the next cycle on it drives CKE low with command inhibit (cs_n=1).
- R6: CKE stays low for the whole time the block is in deep power-down, whatever the other inputs do, until a leave-deep-power-down request.
- R7: After a leave-deep-power-down request, CKE is high with NOP and busy=1 for exactly CLK_MHZ*DPD_WAIT_US cycles before init_start is raised.
- R8: init_start is a one-cycle pulse. The block stays busy and not ready after it until init_done is seen high, and it becomes ready in the cycle after that.
- R9: Any request made while busy is rejected and has no effect. init_done has no effect outside the wait that follows init_start.
- R10: A request that does not fit the current state is rejected and has no effect. These are an exit request while ready, any request other than leave-power-down while in power-down, and any request other than leave-deep-power-down while in deep power-down.
- R11: Two or more requests in the same cycle are all rejected and none takes effect.
- R12: Every rejected request gives req_err=1 for exactly one cycle, in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle | input | 1 | High when all banks are precharged |
| req_pd_enter | input | 1 | Request: enter power-down |
| req_pd_exit | input | 1 | Request: leave power-down |
| req_dpd_enter | input | 1 | Request: enter deep power-down |
| req_dpd_exit | input | 1 | Request: leave deep power-down |
| init_done | input | 1 | External initialisation engine finished |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| busy | output | 1 | Block is in a transition state |
| ready | output | 1 | Device awake and usable for normal commands |
| init_start | output | 1 | One-cycle pulse that starts re-initialisation |
| req_err | output | 1 | One-cycle pulse: previous request rejected |

## Verification
Two pairs of events can fall on the same clock edge. The first is the end of re-initialisation coinciding with a new request. The bench raises init_done and an enter-power-down request in the same cycle of the post-init wait. It expects the request to be rejected, because the block was still busy when the request was sampled. It also expects the block to become ready without ever dropping CKE. The second pair is an enter request coinciding with banks_idle low. The bench expects rejection with CKE left high. In the same way, a busy-time request made during the CKE setup window after power-down exit must be rejected and must not stretch or redirect that window.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE      = 4'd0,
    ST_PD_ENTER  = 4'd1,
    ST_PD        = 4'd2,
    ST_PD_LEAVE  = 4'd3,
    ST_DPD_ENTER = 4'd4,
    ST_DPD       = 4'd5,
    ST_DPD_WAIT  = 4'd6,
    ST_INIT_KICK = 4'd7,
    ST_INIT_WAIT = 4'd8
  } lp_state_e;

  typedef struct packed {
    logic cke;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_pins_t;

  localparam sd_pins_t PINS_NOP_HI = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_pins_t PINS_NOP_LO = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_pins_t PINS_DPD    = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};
  localparam sd_pins_t PINS_INH_LO = '{cke: 1'b0, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/sdram_lp_timer.sv
module sdram_lp_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sdram_lp_req_check.sv
module sdram_lp_req_check
  import sdram_lp_pkg::*;
(
  input  lp_state_e state,
  input  logic      banks_idle,
  input  logic      req_pd_enter,
  input  logic      req_pd_exit,
  input  logic      req_dpd_enter,
  input  logic      req_dpd_exit,
  output logic      go_pd_enter,
  output logic      go_pd_exit,
  output logic      go_dpd_enter,
  output logic      go_dpd_exit,
  output logic      reject
);
  logic [3:0] reqs;
  logic       single;
  logic       any;
  logic       legal;

  assign reqs   = {req_pd_enter, req_pd_exit, req_dpd_enter, req_dpd_exit};
  assign any    = |reqs;
  assign single = ($countones(reqs) == 1);

  always_comb begin
    unique case (state)
      ST_IDLE: legal = (req_pd_enter | req_dpd_enter) & banks_idle;
      ST_PD:   legal = req_pd_exit;
      ST_DPD:  legal = req_dpd_exit;
      default: legal = 1'b0;
    endcase
  end

  assign go_pd_enter  = single & legal & req_pd_enter;
  assign go_pd_exit   = single & legal & req_pd_exit;
  assign go_dpd_enter = single & legal & req_dpd_enter;
  assign go_dpd_exit  = single & legal & req_dpd_exit;
  assign reject       = any & ~(single & legal);
endmodule

// File: rtl/sdram_lp_cmd_enc.sv
module sdram_lp_cmd_enc
  import sdram_lp_pkg::*;
(
  input  lp_state_e state,
  output sd_pins_t  pins,
  output logic      busy,
  output logic      ready,
  output logic      init_start
);
  always_comb begin
    unique case (state)
      ST_PD_ENTER, ST_PD:  pins = PINS_NOP_LO;
      ST_DPD_ENTER:        pins = PINS_DPD;
      ST_DPD:              pins = PINS_INH_LO;
      default:             pins = PINS_NOP_HI;
    endcase
  end

  assign ready      = (state == ST_IDLE);
  assign busy       = !(state inside {ST_IDLE, ST_PD, ST_DPD});
  assign init_start = (state == ST_INIT_KICK);
endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
  import sdram_lp_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int DPD_WAIT_US = 200,
  parameter int CKS_CYCLES  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic banks_idle,
  input  logic req_pd_enter,
  input  logic req_pd_exit,
  input  logic req_dpd_enter,
  input  logic req_dpd_exit,
  input  logic init_done,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic busy,
  output logic ready,
  output logic init_start,
  output logic req_err
);
  localparam int WAIT_CYCLES = CLK_MHZ * DPD_WAIT_US;
  localparam int MAX_CYC     = (WAIT_CYCLES > CKS_CYCLES) ? WAIT_CYCLES : CKS_CYCLES;
  localparam int TW          = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] CKS_LOAD  = TW'(CKS_CYCLES - 1);
  localparam logic [TW-1:0] WAIT_LOAD = TW'(WAIT_CYCLES - 1);

  lp_state_e state, state_nx;
  sd_pins_t  pins;
  logic      go_pd_enter, go_pd_exit, go_dpd_enter, go_dpd_exit, reject;
  logic      tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;

  sdram_lp_req_check u_chk_req (
    .state        (state),
    .banks_idle   (banks_idle),
    .req_pd_enter (req_pd_enter),
    .req_pd_exit  (req_pd_exit),
    .req_dpd_enter(req_dpd_enter),
    .req_dpd_exit (req_dpd_exit),
    .go_pd_enter  (go_pd_enter),
    .go_pd_exit   (go_pd_exit),
    .go_dpd_enter (go_dpd_enter),
    .go_dpd_exit  (go_dpd_exit),
    .reject       (reject)
  );

  assign tmr_load = go_pd_exit | go_dpd_exit;
  assign tmr_val  = go_pd_exit ? CKS_LOAD : WAIT_LOAD;

  sdram_lp_timer #(.TW(TW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: begin
        if (go_pd_enter)       state_nx = ST_PD_ENTER;
        else if (go_dpd_enter) state_nx = ST_DPD_ENTER;
      end
      ST_PD_ENTER:  state_nx = ST_PD;
      ST_PD:        if (go_pd_exit) state_nx = ST_PD_LEAVE;
      ST_PD_LEAVE:  if (tmr_zero) state_nx = ST_IDLE;
      ST_DPD_ENTER: state_nx = ST_DPD;
      ST_DPD:       if (go_dpd_exit) state_nx = ST_DPD_WAIT;
      ST_DPD_WAIT:  if (tmr_zero) state_nx = ST_INIT_KICK;
      ST_INIT_KICK: state_nx = ST_INIT_WAIT;
      ST_INIT_WAIT: if (init_done) state_nx = ST_IDLE;
      default:      state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      req_err <= 1'b0;
    end else begin
      state   <= state_nx;
      req_err <= reject;
    end
  end

  sdram_lp_cmd_enc u_enc (
    .state     (state),
    .pins      (pins),
    .busy      (busy),
    .ready     (ready),
    .init_start(init_start)
  );

  assign cke   = pins.cke;
  assign cs_n  = pins.cs_n;
  assign ras_n = pins.ras_n;
  assign cas_n = pins.cas_n;
  assign we_n  = pins.we_n;
endmodule

// File: rtl/sdram_lp_seq_chk.sv
module sdram_lp_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic banks_idle,
  input logic req_pd_enter,
  input logic req_pd_exit,
  input logic req_dpd_enter,
  input logic req_dpd_exit,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic busy,
  input logic ready,
  input logic init_start,
  input logic req_err
);
  logic one_req;
  logic any_req;
  assign any_req = req_pd_enter | req_pd_exit | req_dpd_enter | req_dpd_exit;
  assign one_req = $countones({req_pd_enter, req_pd_exit, req_dpd_enter, req_dpd_exit}) == 1;

  // R1: ready and busy are never both set
  a_r1_ready_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !busy);

  // R2: a legal power-down entry drops CKE with NOP next cycle
  a_r2_pd_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && one_req && req_pd_enter && banks_idle) |=> (!cke && !cs_n && we_n && busy));

  // R3: entry with active banks is refused, device stays awake
  a_r3_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_pd_enter && !banks_idle) |=> (req_err && ready && cke));

  // R5: the deep power-down command is followed by inhibit with CKE low
  a_r5_dpd_then_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !cs_n && !we_n && ras_n && cas_n) |=> (!cke && cs_n));

  // R6: CKE held low in deep power-down until the exit request
  a_r6_cke_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && cs_n && !req_dpd_exit) |=> !cke);

  // R8: init_start lasts one cycle and keeps the block busy afterwards
  a_r8_init_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> (!init_start && busy && !ready));

  // R9: any request while busy is answered by an error pulse
  a_r9_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && any_req) |=> req_err);

  // R12: no error pulse without a request in the previous cycle
  a_r12_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_req) |=> !req_err);
endmodule

bind sdram_lp_seq sdram_lp_seq_chk u_lp_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .banks_idle   (banks_idle),
  .req_pd_enter (req_pd_enter),
  .req_pd_exit  (req_pd_exit),
  .req_dpd_enter(req_dpd_enter),
  .req_dpd_exit (req_dpd_exit),
  .cke          (cke),
  .cs_n         (cs_n),
  .ras_n        (ras_n),
  .cas_n        (cas_n),
  .we_n         (we_n),
  .busy         (busy),
  .ready        (ready),
  .init_start   (init_start),
  .req_err      (req_err)
);

// File: tb/sim_sdram_lp_seq.sv
module sim_sdram_lp_seq;
  localparam int MHZ = 50;
  localparam int US  = 200;
  localparam int CKS = 2;
  localparam int W   = MHZ * US;

  localparam int P_NOP_HI = 5'b10111;
  localparam int P_NOP_LO = 5'b00111;
  localparam int P_DPD    = 5'b00110;
  localparam int P_INH_LO = 5'b01111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic banks_idle = 1'b1;
  logic r_pe = 1'b0, r_px = 1'b0, r_de = 1'b0, r_dx = 1'b0;
  logic init_done = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, busy, ready, init_start, req_err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sdram_lp_seq #(.CLK_MHZ(MHZ), .DPD_WAIT_US(US), .CKS_CYCLES(CKS)) u0 (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle),
    .req_pd_enter(r_pe), .req_pd_exit(r_px), .req_dpd_enter(r_de), .req_dpd_exit(r_dx),
    .init_done(init_done),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .busy(busy), .ready(ready), .init_start(init_start), .req_err(req_err)
  );

  function automatic int pins();
    return int'({cke, cs_n, ras_n, cas_n, we_n});
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // mask order: {pd_enter, pd_exit, dpd_enter, dpd_exit}; returns at the next falling edge
  task automatic drive(input logic [3:0] m);
    {r_pe, r_px, r_de, r_dx} = m;
    @(negedge clk);
    {r_pe, r_px, r_de, r_dx} = 4'b0000;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 pins", pins(), P_NOP_HI);
    chk("R1 ready", int'(ready), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 req_err", int'(req_err), 0);
    chk("R1 init_start", int'(init_start), 0);
  endtask

  task automatic t_pd_cycle();
    drive(4'b1000);
    chk("R2 entry pins", pins(), P_NOP_LO);
    chk("R2 entry busy", int'(busy), 1);
    @(negedge clk);
    chk("R2 held busy", int'(busy), 0);
    chk("R2 held ready", int'(ready), 0);
    idle_cycles(5);
    chk("R2 held pins", pins(), P_NOP_LO);
    drive(4'b0100);
    chk("R4 exit pins", pins(), P_NOP_HI);
    chk("R4 exit busy c1", int'(busy), 1);
    @(negedge clk);
    chk("R4 exit busy c2", int'(busy), 1);
    @(negedge clk);
    chk("R4 ready after setup", int'(ready), 1);
    chk("R4 busy after setup", int'(busy), 0);
  endtask

  task automatic t_not_idle();
    banks_idle = 1'b0;
    drive(4'b1000);
    chk("R3 pd err", int'(req_err), 1);
    chk("R3 pd ready", int'(ready), 1);
    chk("R3 pd pins", pins(), P_NOP_HI);
    @(negedge clk);
    chk("R12 err one cycle", int'(req_err), 0);
    drive(4'b0010);
    chk("R3 dpd err", int'(req_err), 1);
    chk("R3 dpd pins", pins(), P_NOP_HI);
    banks_idle = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_illegal();
    drive(4'b0100);
    chk("R10 exit from idle err", int'(req_err), 1);
    chk("R10 exit from idle ready", int'(ready), 1);
    drive(4'b0001);
    chk("R10 dpd exit from idle err", int'(req_err), 1);
    drive(4'b1000);
    @(negedge clk);
    drive(4'b0010);
    chk("R10 dpd enter in pd err", int'(req_err), 1);
    chk("R10 dpd enter in pd pins", pins(), P_NOP_LO);
    chk("R10 dpd enter in pd ready", int'(ready), 0);
    drive(4'b0100);
    idle_cycles(CKS);
    chk("R10 back to ready", int'(ready), 1);
  endtask

  task automatic t_multi();
    drive(4'b1010);
    chk("R11 multi err", int'(req_err), 1);
    chk("R11 multi ready", int'(ready), 1);
    chk("R11 multi pins", pins(), P_NOP_HI);
    @(negedge clk);
    chk("R11 no late effect", pins(), P_NOP_HI);
  endtask

  task automatic t_busy_reject();
    drive(4'b1000);
    @(negedge clk);
    drive(4'b0100);
    drive(4'b1000);
    chk("R9 busy err", int'(req_err), 1);
    chk("R9 still in setup", int'(busy), 1);
    @(negedge clk);
    chk("R9 setup not stretched", int'(ready), 1);
    @(negedge clk);
    chk("R9 request had no effect", pins(), P_NOP_HI);
  endtask

  task automatic t_dpd_full();
    int n;
    drive(4'b0010);
    chk("R5 dpd command", pins(), P_DPD);
    chk("R5 busy", int'(busy), 1);
    @(negedge clk);
    chk("R5 inhibit", pins(), P_INH_LO);
    chk("R5 not ready", int'(ready), 0);
    init_done = 1'b1;
    @(negedge clk);
    init_done = 1'b0;
    chk("R9 init_done ignored in dpd", pins(), P_INH_LO);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (cke !== 1'b0) n++;
      @(negedge clk);
    end
    chk("R6 cke low cycles violated", n, 0);
    drive(4'b0001);
    chk("R7 wait pins", pins(), P_NOP_HI);
    n = 0;
    while (!init_start && n < W + 10) begin
      n++;
      @(negedge clk);
    end
    chk("R7 wait length", n, W);
    chk("R8 busy at start", int'(busy), 1);
    @(negedge clk);
    chk("R8 start one cycle", int'(init_start), 0);
    idle_cycles(3);
    chk("R8 waiting busy", int'(busy), 1);
    chk("R8 waiting not ready", int'(ready), 0);
    init_done = 1'b1;
    r_pe = 1'b1;
    @(negedge clk);
    init_done = 1'b0;
    r_pe = 1'b0;
    chk("R9 collision err", int'(req_err), 1);
    chk("R8 ready after done", int'(ready), 1);
    @(negedge clk);
    chk("R9 collision no pd", pins(), P_NOP_HI);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pd_cycle();
    t_not_idle();
    t_illegal();
    t_multi();
    t_busy_reject();
    t_dpd_full();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule